// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel with six operating modes. A count-enable strobe advances it, a gate input qualifies or retriggers it, and a load strobe brings in a new initial count together with a mode code. It produces a live count value that an external latch can capture, plus one OUT line. The OUT waveform depends on the mode: a terminal-count flag, a retriggerable one-shot, a rate generator, a square wave, or a single strobe started by the load or by the gate.

The count is CNT_W bits wide. A loaded value of zero stands for 2^CNT_W ticks. The mode and the count are taken on the load strobe. A load always aborts whatever the channel was doing. Counting starts with the first enabled tick after the load cycle, and a tick in the same cycle as the load is not counted. In the one-shot, rate, square and gate-strobe modes, a rising gate edge restarts the count from the loaded value. In the terminal-count and software-strobe modes, the gate only pauses and resumes counting.

Top module: `interval_channel`

## Requirements
- R1: A loaded value of 0 is treated as 2^CNT_W: count_o reads 0 after the load, and in mode 0 OUT rises only on the 2^CNT_W-th counted tick.
- R2: Mode 0 (code 0): OUT is low after the load, goes high on the tick that takes the count from 1 to 0, and then stays high while the count keeps wrapping modulo 2^CNT_W.
- R3: In modes 0 and 4, ticks that arrive while the gate is low leave count_o and OUT unchanged. Counting resumes when the gate is high again, and the rising gate edge does not restart the count.
- R4: Mode 1 (code 1): after a load, OUT is high and the count holds the loaded value. A rising gate edge reloads the count and drives OUT low, and OUT goes high again after N ticks. A new rising edge during the count starts it over.
- R5: Mode 2 (code 2): OUT goes high on every N-th tick and stays high until the next tick. On that same tick the count reloads to N instead of reaching 0.
- R6: Mode 3 (code 3): in each period of N ticks, OUT is high for the first (N+1)/2 ticks and low for the rest. count_o steps down by two per tick, modulo N within the range 1..N. For N=5 after a load the sequence is 5,3,1,4,2,5.
- R7: Mode 4 (code 4): N ticks after the load, OUT goes high for exactly one tick. Later wraps of the counter produce no further strobe.
- R8: Mode 5 (code 5): the count holds until a rising gate edge. OUT then goes high for one tick, N ticks after that edge. A new edge arms another strobe.
- R9: In modes 2 and 3, a rising gate edge restarts the period from N. In mode 2 OUT returns low, and in mode 3 OUT returns high.
- R10: A load aborts the current count. In the cycle after the load, count_o equals the new value even if a tick arrives in the same cycle as the load.
- R11: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R12: Synchronous reset clears count_o and OUT to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one counted tick per high cycle |
| gate | input | 1 | Gate level (enable or retrigger, depending on mode) |
| load | input | 1 | Load strobe for load_val and mode |
| load_val | input | CNT_W | Initial count, 0 means 2^CNT_W |
| mode | input | 3 | Operating mode code 0..7 |
| count_o | output | CNT_W | Live count value |
| out_o | output | 1 | Channel output |

## Verification
The bench builds the channel with CNT_W=4. At that width the zero-means-full-range load and the modulo wrap after terminal count both fit in 16 ticks. It can therefore confirm that OUT rises on exactly the sixteenth tick and that the software strobe does not repeat when the counter passes zero again. Small odd and even counts exercise the unequal high and low halves of the square wave and the step-by-two visible sequence.

// File: rtl/ic_pkg.sv
package ic_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ic_mode_e;

  // codes 6 and 7 fold onto the rate and square modes (R11)
  function automatic ic_mode_e ic_norm_mode(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return ic_mode_e'(code);
    endcase
  endfunction

  // modes where a rising gate edge restarts the count
  function automatic logic ic_retrig(input ic_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
  endfunction

endpackage

// File: rtl/ic_gate_edge.sv
module ic_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

  // R4
  gate_rise_prev_low_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> gate_q);

endmodule

// File: rtl/ic_load_ctl.sv
module ic_load_ctl
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode_in,
  output ic_mode_e         mode_eff,
  output logic [CNT_W:0]   n_eff
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  ic_mode_e       mode_q;
  logic [CNT_W:0] n_q;
  logic [CNT_W:0] n_d;

  assign n_d = (load_val == '0) ? FULL : {1'b0, load_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_TERM;
      n_q    <= FULL;
    end else if (load) begin
      mode_q <= ic_norm_mode(mode_in);
      n_q    <= n_d;
    end
  end

  assign mode_eff = load ? ic_norm_mode(mode_in) : mode_q;
  assign n_eff    = load ? n_d : n_q;

  // R1
  full_range_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> n_q[CNT_W]);

endmodule

// File: rtl/ic_square_gen.sv
module ic_square_gen #(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           step,
  input  logic [CNT_W:0] n,
  input  logic [CNT_W:0] vis,
  output logic [CNT_W:0] vis_nxt,
  output logic           out_nxt
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] TWO = (CNT_W+1)'(2);

  logic [CNT_W:0] ph;
  logic [CNT_W:0] ph_adv;
  logic [CNT_W:0] half;
  logic [CNT_W:0] wrapped;

  assign half    = (n + ONE) >> 1;
  assign ph_adv  = (ph == n - ONE) ? '0 : ph + ONE;
  assign wrapped = vis + n - TWO;

  always_comb begin
    if (restart) begin
      vis_nxt = n;
      out_nxt = 1'b1;
    end else begin
      if (vis > TWO)          vis_nxt = vis - TWO;
      else if (wrapped == '0) vis_nxt = n;
      else                    vis_nxt = wrapped;
      out_nxt = (ph_adv < half);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ph <= '0;
    else if (restart) ph <= '0;
    else if (step)    ph <= ph_adv;
  end

  // R6
  sq_phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (ph < n));

endmodule

// File: rtl/ic_down_core.sv
module ic_down_core
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             rise,
  input  logic             tick,
  input  logic             gate,
  input  ic_mode_e         mode,
  input  logic [CNT_W-1:0] n_lo,
  input  logic [CNT_W:0]   vis_nxt,
  input  logic             sq_out_nxt,
  output logic             restart,
  output logic             step,
  output logic [CNT_W:0]   cnt,
  output logic             out
);
  localparam logic [CNT_W-1:0] LO_ONE = CNT_W'(1);

  logic           armed;
  logic           done;
  logic           retrig;
  logic           trig;
  logic           advance;
  logic           at_one;
  logic [CNT_W:0] dec;
  logic [CNT_W:0] reload;

  assign retrig  = ic_retrig(mode);
  assign trig    = rise && retrig && !load;
  assign advance = tick && armed && (retrig || gate) && !load && !trig;
  assign at_one  = (cnt[CNT_W-1:0] == LO_ONE);
  assign dec     = {1'b0, cnt[CNT_W-1:0] - LO_ONE};
  assign reload  = {1'b0, n_lo};
  assign restart = (load || trig) && (mode == M_SQUARE);
  assign step    = advance && (mode == M_SQUARE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      out   <= 1'b0;
      armed <= 1'b0;
      done  <= 1'b0;
    end else if (load) begin
      done <= 1'b0;
      cnt  <= (mode == M_SQUARE) ? vis_nxt : reload;
      case (mode)
        M_ONESHOT:  begin out <= 1'b1; armed <= 1'b0; end
        M_SQUARE:   begin out <= 1'b1; armed <= 1'b1; end
        M_HWSTROBE: begin out <= 1'b0; armed <= 1'b0; end
        default:    begin out <= 1'b0; armed <= 1'b1; end
      endcase
    end else if (trig) begin
      armed <= 1'b1;
      done  <= 1'b0;
      cnt   <= (mode == M_SQUARE) ? vis_nxt : reload;
      out   <= (mode == M_SQUARE);
    end else if (advance) begin
      case (mode)
        M_TERM, M_ONESHOT: begin
          cnt <= dec;
          if (at_one) out <= 1'b1;
        end
        M_RATE: begin
          if (at_one) begin
            cnt <= reload;
            out <= 1'b1;
          end else begin
            cnt <= dec;
            out <= 1'b0;
          end
        end
        M_SQUARE: begin
          cnt <= vis_nxt;
          out <= sq_out_nxt;
        end
        M_SWSTROBE, M_HWSTROBE: begin
          cnt <= dec;
          out <= at_one && !done;
          if (at_one) done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2
  term_out_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && mode == M_TERM && out) |=> out);

  // R3
  gate_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !gate && (mode == M_TERM || mode == M_SWSTROBE)) |=> ($stable(cnt) && $stable(out)));

  // R4
  oneshot_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && mode == M_ONESHOT) |=> (out && cnt[CNT_W-1:0] == $past(n_lo)));

  // R5
  rate_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !rise && tick && mode == M_RATE && cnt[CNT_W-1:0] == LO_ONE) |=> (out && cnt[CNT_W-1:0] == $past(n_lo)));

  // R6
  square_vis_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && mode == M_SQUARE) |-> (cnt != '0));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !rise && out && tick && (mode == M_SWSTROBE || mode == M_HWSTROBE) && (gate || mode == M_HWSTROBE)) |=> !out);

  // R8
  hw_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !rise && mode == M_HWSTROBE && !armed) |=> $stable(cnt));

  // R9
  retrig_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && rise && (mode == M_RATE || mode == M_SQUARE)) |=> (cnt[CNT_W-1:0] == $past(n_lo)));

  // R10
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt[CNT_W-1:0] == $past(n_lo)));

endmodule

// File: rtl/interval_channel.sv
module interval_channel
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  ic_mode_e       mode_eff;
  logic [CNT_W:0] n_eff;
  logic           rise;
  logic           restart;
  logic           step;
  logic [CNT_W:0] cnt;
  logic [CNT_W:0] vis_nxt;
  logic           sq_out_nxt;
  logic           out;

  ic_gate_edge u_edge (
    .clk (clk),
    .rst (rst),
    .gate(gate),
    .rise(rise)
  );

  ic_load_ctl #(.CNT_W(CNT_W)) u_load (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .mode_in (mode),
    .mode_eff(mode_eff),
    .n_eff   (n_eff)
  );

  ic_square_gen #(.CNT_W(CNT_W)) u_square (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .step   (step),
    .n      (n_eff),
    .vis    (cnt),
    .vis_nxt(vis_nxt),
    .out_nxt(sq_out_nxt)
  );

  ic_down_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .rise      (rise),
    .tick      (tick),
    .gate      (gate),
    .mode      (mode_eff),
    .n_lo      (n_eff[CNT_W-1:0]),
    .vis_nxt   (vis_nxt),
    .sq_out_nxt(sq_out_nxt),
    .restart   (restart),
    .step      (step),
    .cnt       (cnt),
    .out       (out)
  );

  assign count_o = cnt[CNT_W-1:0];
  assign out_o   = out;

  // R1
  zero_load_count_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> (count_o == '0));

endmodule

// File: tb/interval_channel_tb_top.sv
`timescale 1ns/1ps
module interval_channel_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         gate = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [2:0]   mode = 3'd0;
  logic [W-1:0] count_o;
  logic         out_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  interval_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load(load),
    .load_val(load_val), .mode(mode), .count_o(count_o), .out_o(out_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] ec, input logic eo);
    checks++;
    if (count_o !== ec || out_o !== eo) begin
      errors++;
      $display("FAIL %s: count=%0d out=%0b expected count=%0d out=%0b", tag, count_o, out_o, ec, eo);
    end
  endtask

  task automatic clk1(input logic t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) clk1(1'b1);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [W-1:0] v, input logic t);
    mode = m; load_val = v; load = 1'b1;
    clk1(t);
    load = 1'b0;
  endtask

  task automatic trig();
    gate = 1'b0; clk1(1'b0);
    gate = 1'b1; clk1(1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R12 reset", 4'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 after reset", 4'd0, 1'b0);
  endtask

  task automatic t_term();
    do_load(3'd0, 4'd5, 1'b1);
    chk("R10 tick with load ignored", 4'd5, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      ticks(1);
      chk("R2 counting", 4'(5 - k), 1'b0);
    end
    ticks(1); chk("R2 terminal", 4'd0, 1'b1);
    ticks(1); chk("R2 wrap sticky", 4'd15, 1'b1);
    clk1(1'b0); chk("R2 idle cycle", 4'd15, 1'b1);
  endtask

  task automatic t_zero();
    do_load(3'd0, 4'd0, 1'b0);
    chk("R1 zero load", 4'd0, 1'b0);
    ticks(15); chk("R1 before full range", 4'd1, 1'b0);
    ticks(1);  chk("R1 full range", 4'd0, 1'b1);
  endtask

  task automatic t_gate_hold();
    do_load(3'd0, 4'd6, 1'b0);
    ticks(2); chk("R3 mode0 run", 4'd4, 1'b0);
    gate = 1'b0;
    ticks(3); chk("R3 mode0 gate low hold", 4'd4, 1'b0);
    gate = 1'b1;
    ticks(3); chk("R3 mode0 resume", 4'd1, 1'b0);
    ticks(1); chk("R3 mode0 terminal", 4'd0, 1'b1);
    do_load(3'd4, 4'd3, 1'b0);
    ticks(1); chk("R3 mode4 run", 4'd2, 1'b0);
    gate = 1'b0;
    ticks(4); chk("R3 mode4 gate low hold", 4'd2, 1'b0);
    gate = 1'b1;
    ticks(2); chk("R3 mode4 resume strobe", 4'd0, 1'b1);
  endtask

  task automatic t_oneshot();
    do_load(3'd1, 4'd3, 1'b0);
    chk("R4 after load", 4'd3, 1'b1);
    ticks(2); chk("R4 held before trigger", 4'd3, 1'b1);
    trig();   chk("R4 trigger", 4'd3, 1'b0);
    ticks(1); chk("R4 count 2", 4'd2, 1'b0);
    ticks(1); chk("R4 count 1", 4'd1, 1'b0);
    ticks(1); chk("R4 expire", 4'd0, 1'b1);
    ticks(1); chk("R4 wrap high", 4'd15, 1'b1);
    trig();   chk("R4 second trigger", 4'd3, 1'b0);
    ticks(1); chk("R4 mid count", 4'd2, 1'b0);
    trig();   chk("R4 retrigger restart", 4'd3, 1'b0);
    ticks(3); chk("R4 expire after retrigger", 4'd0, 1'b1);
  endtask

  task automatic t_rate();
    do_load(3'd2, 4'd4, 1'b0);
    chk("R5 after load", 4'd4, 1'b0);
    ticks(1); chk("R5 3", 4'd3, 1'b0);
    ticks(1); chk("R5 2", 4'd2, 1'b0);
    ticks(1); chk("R5 1", 4'd1, 1'b0);
    ticks(1); chk("R5 pulse and reload", 4'd4, 1'b1);
    clk1(1'b0); chk("R5 pulse holds to next tick", 4'd4, 1'b1);
    ticks(1); chk("R5 pulse ends", 4'd3, 1'b0);
    ticks(2); chk("R5 second period", 4'd1, 1'b0);
    ticks(1); chk("R5 second pulse", 4'd4, 1'b1);
    ticks(2); chk("R9 mode2 before restart", 4'd2, 1'b0);
    trig();   chk("R9 mode2 restart", 4'd4, 1'b0);
  endtask

  task automatic t_square();
    logic [W-1:0] seq5 [5] = '{4'd3, 4'd1, 4'd4, 4'd2, 4'd5};
    logic         out5 [5] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    logic [W-1:0] seq4 [4] = '{4'd2, 4'd4, 4'd2, 4'd4};
    logic         out4 [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
    do_load(3'd3, 4'd5, 1'b0);
    chk("R6 odd load", 4'd5, 1'b1);
    for (int i = 0; i < 5; i++) begin
      ticks(1); chk("R6 odd period", seq5[i], out5[i]);
    end
    do_load(3'd3, 4'd4, 1'b0);
    chk("R6 even load", 4'd4, 1'b1);
    for (int i = 0; i < 4; i++) begin
      ticks(1); chk("R6 even period", seq4[i], out4[i]);
    end
    do_load(3'd3, 4'd5, 1'b0);
    ticks(3); chk("R9 mode3 before restart", 4'd4, 1'b0);
    trig();   chk("R9 mode3 restart", 4'd5, 1'b1);
    ticks(1); chk("R9 mode3 after restart", 4'd3, 1'b1);
  endtask

  task automatic t_alias();
    do_load(3'd7, 4'd4, 1'b0);
    chk("R11 code7 load", 4'd4, 1'b1);
    ticks(1); chk("R11 code7 step", 4'd2, 1'b1);
    ticks(1); chk("R11 code7 low half", 4'd4, 1'b0);
    do_load(3'd6, 4'd3, 1'b0);
    chk("R11 code6 load", 4'd3, 1'b0);
    ticks(2); chk("R11 code6 count", 4'd1, 1'b0);
    ticks(1); chk("R11 code6 pulse reload", 4'd3, 1'b1);
  endtask

  task automatic t_swstrobe();
    do_load(3'd4, 4'd3, 1'b0);
    chk("R7 after load", 4'd3, 1'b0);
    ticks(2); chk("R7 count 1", 4'd1, 1'b0);
    ticks(1); chk("R7 strobe", 4'd0, 1'b1);
    ticks(1); chk("R7 strobe ends", 4'd15, 1'b0);
    ticks(15); chk("R7 no strobe on wrap", 4'd0, 1'b0);
  endtask

  task automatic t_hwstrobe();
    do_load(3'd5, 4'd2, 1'b0);
    chk("R8 after load", 4'd2, 1'b0);
    ticks(3); chk("R8 held before trigger", 4'd2, 1'b0);
    trig();   chk("R8 trigger", 4'd2, 1'b0);
    ticks(1); chk("R8 count 1", 4'd1, 1'b0);
    ticks(1); chk("R8 strobe", 4'd0, 1'b1);
    ticks(1); chk("R8 strobe ends", 4'd15, 1'b0);
    trig();   chk("R8 rearm", 4'd2, 1'b0);
    ticks(2); chk("R8 second strobe", 4'd0, 1'b1);
  endtask

  task automatic t_abort();
    do_load(3'd0, 4'd9, 1'b0);
    ticks(3); chk("R10 running", 4'd6, 1'b0);
    do_load(3'd0, 4'd2, 1'b1);
    chk("R10 abort reload", 4'd2, 1'b0);
    ticks(2); chk("R10 new terminal", 4'd0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_term();
    t_zero();
    t_gate_hold();
    t_oneshot();
    t_rate();
    t_square();
    t_alias();
    t_swstrobe();
    t_hwstrobe();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule